// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

This block controls a set of general-purpose pads through a word-addressed register bus. The pads are grouped 32 to a bank. Each register kind has one 32-bit word per bank:

- enable
- output data
- direction
- synchronised input
- interrupt mask
- interrupt status
- edge select

The controller drives each pad's output value and output enable. Pad inputs pass through a two-flop synchroniser, and each pin's input can raise an interrupt. Status bits are latched per pin and combined into one registered interrupt line.

The register polarities are inverted relative to common practice. A set direction bit makes a pin an input, and a set mask bit blocks its interrupt. Status bits are cleared by writing zeros, so software clears exactly what it saw by writing back the complement of the value it read.

A parameter selects a fixed non-identity pin-to-bit map. Under that map, physical pins sit at shuffled register positions and a few pins have no bit at all. A second parameter removes the edge-select register; in that case interrupts become active-high level interrupts.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the enable, output-data, edge-select and status words read 0. The direction and mask words read 1 on every mapped bit. `irq` is 0 and no pad has its output enable asserted.
- R2: The bus address is `{kind[2:0], bank}`, with kind codes enable=0, output data=1, direction=2, input=3, mask=4, status=5, edge select=6. Under the identity map, pin p lives at bit p mod 32 of bank p div 32. Kind 7 and banks beyond the last read 0.
- R3: A pad's output enable is 1 only when its enable bit is 1 and its direction bit is 0. When it is driven, the pad's output equals its output-data bit.
- R4: The input word returns each pad's level after a two-flop synchroniser. A pad change first becomes visible after the second rising clock edge.
- R5: With the edge-select register present, an edge-select bit of 1 latches status on a rising input edge, and 0 latches it on a falling edge. The status bit is set at the third rising clock edge after the pad change.
- R6: A pin whose mask bit is 1, or whose enable bit is 0, never sets its status bit.
- R7: A write to a status word clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing the complement of a read value clears exactly the bits that were read as pending.
- R8: When a pin's event and a clearing write of its status bit land on the same clock edge, the bit ends up set.
- R9: `irq` is a register holding the OR of all status bits. It rises one clock after the first status bit is set and falls one clock after the last one is cleared.
- R10: A register bit with no mapped pin reads 0 in every kind, ignores writes, and never reports status. This includes the bits at or above the pin count in the last bank.
- R11: With the remap enabled, pins 0–27 use bit pin+4, pins 34–97 use bit pin−2, and pins 98–101 use bit 101−pin. Pins 28–33 have no register bit and no pad drive.
- R12: Without the edge-select register, status is set on every cycle in which an enabled, unmasked input is high, so it cannot be cleared while that input stays high. The edge-select word reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | `{kind, bank}` word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pad_in | input | 102 | Asynchronous pad input levels |
| pad_out | output | 102 | Pad output values |
| pad_oe | output | 102 | Pad output enables |
| irq | output | 1 | Combined registered interrupt |

## Verification
A vector table drives single-pin transitions under both edge-select settings: rising, falling, a falling pin with rising select, and an unchanged level. These cases separate a correct edge choice from a detector that fires on any change or on the wrong polarity, and they cover pins in both banks and at bank borders. Directed sequences count edges to pin down the synchroniser and interrupt latencies. They also race an event against a clearing write, and apply partial clear masks that show whether write-zero-to-clear keeps its ones. A second instance with the remap and level mode drives pins at each map segment and an unmapped pin, which exposes off-by-segment mapping errors and any clear that wrongly succeeds while the level is still high.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        RK_ENABLE = 3'd0,
        RK_DOUT   = 3'd1,
        RK_DIR    = 3'd2,
        RK_DIN    = 3'd3,
        RK_MASK   = 3'd4,
        RK_STAT   = 3'd5,
        RK_ETYPE  = 3'd6
    } reg_kind_e;

    typedef struct packed {
        logic      wr;
        reg_kind_e kind;
    } bus_dec_t;

    function automatic int bank_count(input int num_pins);
        return (num_pins + WORD_W - 1) / WORD_W;
    endfunction

    // Register bit used by a physical pin, -1 when the pin has none.
    function automatic int pin_to_bit(input int pin, input int num_pins, input bit remap);
        if (pin < 0 || pin >= num_pins) return -1;
        if (!remap)    return pin;
        if (pin <= 27) return pin + 4;
        if (pin <= 33) return -1;
        if (pin <= 97) return pin - 2;
        if (pin <= 101) return 101 - pin;
        return -1;
    endfunction

    // Physical pin served by a register bit, -1 when the bit is unmapped.
    function automatic int bit_to_pin(input int b, input int num_pins, input bit remap);
        for (int p = 0; p < num_pins; p++) begin
            if (pin_to_bit(p, num_pins, remap) == b) return p;
        end
        return -1;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W        = 8,
    parameter bit HAS_EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] evt
);
    if (HAS_EDGE) begin : g_edge
        logic [W-1:0] prev_q;

        always_ff @(posedge clk) begin
            if (rst) prev_q <= '0;
            else     prev_q <= cur;
        end

        assign evt = (cur & ~prev_q & rise_sel) | (~cur & prev_q & ~rise_sel);
    end else begin : g_level
        logic unused_sel;
        assign unused_sel = ^rise_sel;
        assign evt        = cur;
    end
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] keep,
    output logic [W-1:0] stat,
    output logic         irq
);
    logic [W-1:0] stat_q;
    logic         irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            // a new event wins over a clearing write in the same cycle
            stat_q <= (stat_q & keep) | hit;
            irq_q  <= |stat_q;
        end
    end

    assign stat = stat_q;
    assign irq  = irq_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 102,
    parameter bit REMAP    = 1'b0,
    parameter bit HAS_EDGE = 1'b1,
    localparam int BANKS   = bank_count(NUM_PINS),
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W  = 3 + BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int NBITS = BANKS * WORD_W;

    logic [NBITS-1:0]    bit_valid;
    logic [NBITS-1:0]    in_bits;
    logic [NUM_PINS-1:0] pin_sync;

    logic [NBITS-1:0] en_q, dout_q, dir_q, mask_q, etype_q;
    logic [NBITS-1:0] wr_lane, wr_full, stat_keep;
    logic [NBITS-1:0] evt_bits, hit, stat_bits, rd_src;

    bus_dec_t          acc;
    logic [BANK_W-1:0] acc_bank;

    assign acc.wr   = bus_we;
    assign acc.kind = reg_kind_e'(bus_addr[ADDR_W-1 -: 3]);
    assign acc_bank = bus_addr[BANK_W-1:0];

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Bit side of the map: which pin feeds each register bit.
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        localparam int PB = bit_to_pin(b, NUM_PINS, REMAP);
        if (PB >= 0) begin : g_mapped
            assign bit_valid[b] = 1'b1;
            assign in_bits[b]   = pin_sync[PB];
        end else begin : g_unmapped
            assign bit_valid[b] = 1'b0;
            assign in_bits[b]   = 1'b0;
        end
    end

    // Pin side of the map: which register bit drives each pad.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BP = pin_to_bit(p, NUM_PINS, REMAP);
        if (BP >= 0) begin : g_mapped
            assign pad_out[p] = dout_q[BP];
            assign pad_oe[p]  = en_q[BP] & ~dir_q[BP];
        end else begin : g_unmapped
            assign pad_out[p] = 1'b0;
            assign pad_oe[p]  = 1'b0;
        end
    end

    // Spread the bus word over the addressed bank; unmapped bits never written.
    always_comb begin
        wr_lane = '0;
        wr_full = '0;
        for (int k = 0; k < BANKS; k++) begin
            if (acc_bank == BANK_W'(k)) begin
                wr_lane[k*WORD_W +: WORD_W] = '1;
                wr_full[k*WORD_W +: WORD_W] = bus_wdata;
            end
        end
        wr_lane = wr_lane & bit_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            dout_q  <= '0;
            dir_q   <= bit_valid;
            mask_q  <= bit_valid;
            etype_q <= '0;
        end else if (acc.wr) begin
            case (acc.kind)
                RK_ENABLE: en_q   <= (en_q   & ~wr_lane) | (wr_full & wr_lane);
                RK_DOUT:   dout_q <= (dout_q & ~wr_lane) | (wr_full & wr_lane);
                RK_DIR:    dir_q  <= (dir_q  & ~wr_lane) | (wr_full & wr_lane);
                RK_MASK:   mask_q <= (mask_q & ~wr_lane) | (wr_full & wr_lane);
                RK_ETYPE: begin
                    if (HAS_EDGE) etype_q <= (etype_q & ~wr_lane) | (wr_full & wr_lane);
                end
                default: ;
            endcase
        end
    end

    // Zero-to-clear: a written 0 on a mapped bit drops it, a 1 keeps it.
    always_comb begin
        if (acc.wr && acc.kind == RK_STAT) stat_keep = ~(wr_lane & ~wr_full);
        else                                stat_keep = '1;
    end

    gpio_evt_detect #(.W(NBITS), .HAS_EDGE(HAS_EDGE)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .cur      (in_bits),
        .rise_sel (etype_q),
        .evt      (evt_bits)
    );

    assign hit = evt_bits & en_q & ~mask_q & bit_valid;

    gpio_irq_stat #(.W(NBITS)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .keep (stat_keep),
        .stat (stat_bits),
        .irq  (irq)
    );

    always_comb begin
        case (acc.kind)
            RK_ENABLE: rd_src = en_q;
            RK_DOUT:   rd_src = dout_q;
            RK_DIR:    rd_src = dir_q;
            RK_DIN:    rd_src = in_bits;
            RK_MASK:   rd_src = mask_q;
            RK_STAT:   rd_src = stat_bits;
            RK_ETYPE:  rd_src = etype_q;
            default:   rd_src = '0;
        endcase
        bus_rdata = '0;
        for (int k = 0; k < BANKS; k++) begin
            if (acc_bank == BANK_W'(k)) bus_rdata = rd_src[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NBITS = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic [NBITS-1:0] stat_q,
    input logic [NBITS-1:0] mask_q,
    input logic [NBITS-1:0] dir_q,
    input logic [NBITS-1:0] hit,
    input logic [NBITS-1:0] stat_keep,
    input logic [NBITS-1:0] bit_valid
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == bit_valid && mask_q == bit_valid && stat_q == '0));

    // R6
    masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~$past(stat_q) & $past(mask_q)) == '0);

    // R10
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~bit_valid) == '0);

    // R7
    clear_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_keep) != '1 && $past(hit) == '0) |-> stat_q == ($past(stat_q) & $past(stat_keep)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hit) != '0 |-> (stat_q & $past(hit)) == $past(hit));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(stat_q) != '0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NBITS(NBITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .stat_q    (stat_bits),
    .mask_q    (mask_q),
    .dir_q     (dir_q),
    .hit       (hit),
    .stat_keep (stat_keep),
    .bit_valid (bit_valid)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
    localparam logic [2:0] K_EN = 3'd0, K_DOUT = 3'd1, K_DIR = 3'd2, K_DIN = 3'd3,
                           K_MASK = 3'd4, K_STAT = 3'd5, K_ETYPE = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // instance A: 40 pins, identity map, edge mode
    logic         a_we = 1'b0;
    logic [3:0]   a_addr = '0;
    logic [31:0]  a_wdata = '0, a_rdata;
    logic [39:0]  a_pad = '0, a_out, a_oe;
    logic         a_irq;

    // instance B: 102 pins, remapped, level mode
    logic         b_we = 1'b0;
    logic [4:0]   b_addr = '0;
    logic [31:0]  b_wdata = '0, b_rdata;
    logic [101:0] b_pad = '0, b_out, b_oe;
    logic         b_irq;

    gpio_bank_ctrl #(.NUM_PINS(40), .REMAP(1'b0), .HAS_EDGE(1'b1)) i_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .bus_we(a_we), .bus_addr(a_addr), .bus_wdata(a_wdata),
        .bus_rdata(a_rdata), .pad_in(a_pad), .pad_out(a_out), .pad_oe(a_oe), .irq(a_irq));

    gpio_bank_ctrl #(.NUM_PINS(102), .REMAP(1'b1), .HAS_EDGE(1'b0)) i_gpio_bank_ctrl_remap (
        .clk(clk), .rst(rst), .bus_we(b_we), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_rdata(b_rdata), .pad_in(b_pad), .pad_out(b_out), .pad_oe(b_oe), .irq(b_irq));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        int   pin;
        logic rise;
        logic lvl0;
        logic lvl1;
        logic hit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3,  1'b1, 1'b0, 1'b1, 1'b1},
        '{3,  1'b1, 1'b1, 1'b0, 1'b0},
        '{17, 1'b0, 1'b1, 1'b0, 1'b1},
        '{17, 1'b0, 1'b0, 1'b1, 1'b0},
        '{33, 1'b1, 1'b0, 1'b1, 1'b1},
        '{39, 1'b0, 1'b1, 1'b0, 1'b1},
        '{0,  1'b1, 1'b1, 1'b1, 1'b0},
        '{31, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bus tasks start at a negedge and return at a negedge
    task automatic wr_a(input logic [2:0] k, input int bank, input logic [31:0] d);
        a_we = 1'b1; a_addr = {k, 1'(bank)}; a_wdata = d;
        @(posedge clk); @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic rd_a(input logic [2:0] k, input int bank, output logic [31:0] v);
        a_addr = {k, 1'(bank)}; #1; v = a_rdata;
    endtask

    task automatic wr_b(input logic [2:0] k, input int bank, input logic [31:0] d);
        b_we = 1'b1; b_addr = {k, 2'(bank)}; b_wdata = d;
        @(posedge clk); @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic rd_b(input logic [2:0] k, input int bank, output logic [31:0] v);
        b_addr = {k, 2'(bank)}; #1; v = b_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_cyc(1);

        // R1 / R10 reset state
        rd_a(K_EN, 0, v);    check("R1 enable", v, 32'h0);
        rd_a(K_DIR, 0, v);   check("R1 dir bank0", v, 32'hFFFF_FFFF);
        rd_a(K_DIR, 1, v);   check("R10 dir bank1", v, 32'h0000_00FF);
        rd_a(K_MASK, 1, v);  check("R1 mask bank1", v, 32'h0000_00FF);
        rd_a(K_STAT, 0, v);  check("R1 status", v, 32'h0);
        rd_a(K_ETYPE, 0, v); check("R1 etype", v, 32'h0);
        check("R1 irq", {31'd0, a_irq}, 32'h0);
        check("R1 oe", {31'd0, |a_oe}, 32'h0);

        // R10 write to unmapped bits ignored
        wr_a(K_EN, 1, 32'hFFFF_FFFF);
        rd_a(K_EN, 1, v);    check("R10 enable bank1", v, 32'h0000_00FF);
        rd_a(3'd7, 0, v);    check("R2 unused kind", v, 32'h0);
        wr_a(K_EN, 0, 32'hFFFF_FFFF);
        wr_a(K_MASK, 0, 32'h0);
        wr_a(K_MASK, 1, 32'h0);

        // vector table: R5 edge select and R9 irq
        foreach (VECS[i]) begin
            wr_a(K_ETYPE, 0, VECS[i].rise ? 32'hFFFF_FFFF : 32'h0);
            wr_a(K_ETYPE, 1, VECS[i].rise ? 32'hFFFF_FFFF : 32'h0);
            a_pad[VECS[i].pin] = VECS[i].lvl0;
            wait_cyc(4);
            wr_a(K_STAT, 0, 32'h0);
            wr_a(K_STAT, 1, 32'h0);
            wait_cyc(1);
            a_pad[VECS[i].pin] = VECS[i].lvl1;
            wait_cyc(4);
            rd_a(K_STAT, VECS[i].pin / 32, v);
            check("R5 table status", v, VECS[i].hit ? (32'h1 << (VECS[i].pin % 32)) : 32'h0);
            check("R9 table irq", {31'd0, a_irq}, {31'd0, VECS[i].hit});
        end
        a_pad = '0;
        wait_cyc(4);
        wr_a(K_STAT, 0, 32'h0);
        wr_a(K_STAT, 1, 32'h0);
        wr_a(K_ETYPE, 0, 32'hFFFF_FFFF);
        wait_cyc(2);

        // R4 synchroniser latency
        a_pad[9] = 1'b1;
        wait_cyc(1);
        rd_a(K_DIN, 0, v);   check("R4 din after one edge", v, 32'h0);
        wait_cyc(1);
        rd_a(K_DIN, 0, v);   check("R4 din after two edges", v, 32'h0000_0200);
        // R5 / R9 exact latency
        wait_cyc(1);
        rd_a(K_STAT, 0, v);  check("R5 status after three edges", v, 32'h0000_0200);
        check("R9 irq still low", {31'd0, a_irq}, 32'h0);
        wait_cyc(1);
        check("R9 irq after four edges", {31'd0, a_irq}, 32'h1);
        wr_a(K_STAT, 0, 32'h0);
        wait_cyc(2);

        // R6 masked and disabled pins
        wr_a(K_MASK, 0, 32'h0010_0000);
        wr_a(K_EN, 0, 32'hFFDF_FFFF);
        a_pad[20] = 1'b1; a_pad[21] = 1'b1;
        wait_cyc(5);
        rd_a(K_STAT, 0, v);  check("R6 masked or disabled", v, 32'h0);
        check("R6 irq", {31'd0, a_irq}, 32'h0);
        wr_a(K_MASK, 0, 32'h0);
        wr_a(K_EN, 0, 32'hFFFF_FFFF);

        // R7 partial clear
        a_pad[1] = 1'b1; a_pad[2] = 1'b1;
        wait_cyc(4);
        rd_a(K_STAT, 0, v);  check("R7 two pending", v, 32'h0000_0006);
        wr_a(K_STAT, 0, 32'hFFFF_FFFB);
        rd_a(K_STAT, 0, v);  check("R7 keep ones", v, 32'h0000_0002);
        wr_a(K_STAT, 0, ~32'h0000_0002);
        rd_a(K_STAT, 0, v);  check("R7 complement clears", v, 32'h0);
        check("R9 irq lags clear", {31'd0, a_irq}, 32'h1);
        wait_cyc(1);
        check("R9 irq drops", {31'd0, a_irq}, 32'h0);

        // R8 event and clear on the same edge
        a_pad[12] = 1'b1;
        wait_cyc(2);
        wr_a(K_STAT, 0, 32'h0);
        rd_a(K_STAT, 0, v);  check("R8 set wins", v, 32'h0000_1000);
        wr_a(K_STAT, 0, 32'h0);

        // R3 / R2 pad drive
        wr_a(K_DOUT, 0, 32'h0000_0020);
        wr_a(K_DIR, 0, 32'hFFFF_FFDF);
        wr_a(K_DIR, 1, 32'hFFFF_FFEF);
        check("R3 oe pattern", {31'd0, a_oe == ((40'h1 << 5) | (40'h1 << 36))}, 32'h1);
        check("R3 out pin5", {31'd0, a_out[5]}, 32'h1);
        check("R2 out pin36 bank1", {31'd0, a_out[36]}, 32'h0);
        wr_a(K_EN, 1, 32'h0);
        check("R3 disabled no drive", {31'd0, a_oe[36]}, 32'h0);

        // instance B: R11 remap, R12 level mode
        for (int k = 0; k < 4; k++) begin
            wr_b(K_EN, k, 32'hFFFF_FFFF);
            wr_b(K_MASK, k, 32'h0);
        end
        wr_b(K_ETYPE, 0, 32'hFFFF_FFFF);
        rd_b(K_ETYPE, 0, v); check("R12 etype absent", v, 32'h0);
        rd_b(K_DIR, 3, v);   check("R10 remap bank3", v, 32'h0);

        b_pad[0] = 1'b1;
        wait_cyc(4);
        rd_b(K_STAT, 0, v);  check("R11 pin0 at bit4", v, 32'h0000_0010);
        wr_b(K_STAT, 0, 32'h0);
        rd_b(K_STAT, 0, v);  check("R12 level holds", v, 32'h0000_0010);
        b_pad[0] = 1'b0;
        wait_cyc(3);
        wr_b(K_STAT, 0, 32'h0);
        rd_b(K_STAT, 0, v);  check("R12 clear after low", v, 32'h0);

        b_pad[100] = 1'b1;
        wait_cyc(4);
        rd_b(K_STAT, 0, v);  check("R11 pin100 at bit1", v, 32'h0000_0002);
        rd_b(K_DIN, 0, v);   check("R11 din pin100", v, 32'h0000_0002);
        b_pad[100] = 1'b0;
        wait_cyc(3);
        wr_b(K_STAT, 0, 32'h0);

        b_pad[50] = 1'b1;
        wait_cyc(4);
        rd_b(K_STAT, 1, v);  check("R11 pin50 at bit48", v, 32'h0001_0000);
        b_pad[50] = 1'b0;
        wait_cyc(3);
        wr_b(K_STAT, 1, 32'h0);

        b_pad[30] = 1'b1;
        wait_cyc(4);
        rd_b(K_DIN, 0, v);   check("R11 unsupported din0", v, 32'h0);
        rd_b(K_DIN, 1, v);   check("R11 unsupported din1", v, 32'h0);
        check("R11 unsupported irq", {31'd0, b_irq}, 32'h0);

        wr_b(K_DOUT, 0, 32'h0000_0010);
        wr_b(K_DIR, 0, 32'hFFFF_FFEF);
        check("R11 oe pin0 only", {31'd0, b_oe == 102'd1}, 32'h1);
        check("R11 out pin0", {31'd0, b_out[0]}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule